// File: doc/BRIEF.md
# Washer Program Sequencer

This block is the synchronous sequencing core of a washing machine. Once its run request is held high, it takes the machine through a fixed program. First it empties any water left in the tub. It then takes one cycle to decide the water temperature, fills the tub, and runs three timed phases: agitation, rinse and drying. It watches a tub level sensor and the expiry flag of an external interval timer. At the start of each timed phase it emits a one-cycle request that restarts that timer.

Every output is decoded from registered state only. The actuator enables form a vector in which at most one bit is set. Dropping the run request aborts the program from any phase, and the block then waits in idle with everything off.

Top module: `wash_seq_ctrl`

## Requirements
- R1: While `rst` is sampled high, the block enters idle. In the next cycle `act_en` is 0, `timer_start` is 0 and `done` is 0.
- R2: In idle the block stays put, with all outputs 0, while `start` is 0. A clock edge that samples `start` = 1 moves it to the drain phase.
- R3: In the drain phase only `act_en[0]` (drain pump) is set. A clock edge that samples `tub_empty` = 1 moves the block to a one-cycle temperature-select phase in which `act_en` is 0.
- R4: The edge that leaves the select phase captures `hot_cold`. During fill, `act_en[1]` (hot valve) is set if the captured value is 1 and `act_en[2]` (cold valve) is set if it is 0. Changes on `hot_cold` after that edge have no effect on the run.
- R5: Fill holds until an edge samples `tub_empty` = 0 (tub full). The block then enters the wash phase.
- R6: Wash sets `act_en[3]`, rinse sets `act_en[4]` and dry sets `act_en[5]`. In the first cycle of each of these phases, `timer_start` is 1 for exactly one cycle.
- R7: A timed phase advances (wash to rinse, rinse to dry, dry to finish) only on an edge that samples `time_over` = 1 outside the phase's first cycle. A `time_over` of 1 seen during the first cycle is ignored.
- R8: After dry, the block spends one cycle with `done` = 1 and `act_en` = 0, then returns to idle.
- R9: If an edge samples `start` = 0 in any phase other than idle, the next cycle is idle with `act_en`, `timer_start` and `done` all 0.
- R10: At most one bit of `act_en` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Run request: 1 runs the program, 0 stops it |
| hot_cold | input | 1 | Temperature choice: 1 hot, 0 cold |
| tub_empty | input | 1 | Level sensor: 1 tub fully empty, 0 tub full |
| time_over | input | 1 | External timer: 1 interval ended, 0 still running |
| act_en | output | ACT_W (6) | One-hot actuator enables: bit 0 drain, 1 hot valve, 2 cold valve, 3 wash motor, 4 rinse, 5 dryer |
| timer_start | output | 1 | One-cycle request to restart the external timer |
| done | output | 1 | One-cycle program-complete indication |

## Verification
The properties assume that inputs are synchronous to `clk` and that they change only between edges. They also assume that `rst` is applied before any result is expected, because each property is disabled while reset is high. The bench changes every input on the falling edge, so the design and the bench model see the same values at each rising edge. Its random section keeps `start` mostly high, so that full programs do complete, but it still drops the run request in every phase. The directed runs hold `time_over` high during the first cycle of a timed phase so that the R7 rule is exercised.

// File: rtl/wash_pkg.sv
package wash_pkg;

   // Program phases. The encoding order is also the program order.
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_DRAIN  = 3'd1,
      PH_SELECT = 3'd2,
      PH_FILL   = 3'd3,
      PH_WASH   = 3'd4,
      PH_RINSE  = 3'd5,
      PH_DRY    = 3'd6,
      PH_FINISH = 3'd7
   } phase_t;

   localparam int unsigned ACT_COUNT = 6;
   localparam int unsigned ACT_DRAIN = 0;
   localparam int unsigned ACT_HOT   = 1;
   localparam int unsigned ACT_COLD  = 2;
   localparam int unsigned ACT_WASH  = 3;
   localparam int unsigned ACT_RINSE = 4;
   localparam int unsigned ACT_DRY   = 5;

   // Phase that owns a given actuator bit. The valve bits share the fill phase.
   function automatic phase_t owner_phase(input int unsigned idx);
      case (idx)
         ACT_DRAIN:          return PH_DRAIN;
         ACT_HOT, ACT_COLD:  return PH_FILL;
         ACT_WASH:           return PH_WASH;
         ACT_RINSE:          return PH_RINSE;
         default:            return PH_DRY;
      endcase
   endfunction

   function automatic logic is_timed(input phase_t ph);
      return (ph == PH_WASH) || (ph == PH_RINSE) || (ph == PH_DRY);
   endfunction

endpackage

// File: rtl/wash_next_phase.sv
module wash_next_phase
   import wash_pkg::*;
(
   input  phase_t phase_q,
   input  logic   start,
   input  logic   tub_empty,
   input  logic   time_over,
   input  logic   entry_q,
   output phase_t phase_d
);

   logic tick_ok;

   // An expiry flag seen in the first cycle of a timed phase is stale.
   assign tick_ok = time_over && !entry_q;

   always_comb begin
      phase_d = phase_q;
      if (phase_q != PH_IDLE && !start) begin
         phase_d = PH_IDLE;
      end else begin
         unique case (phase_q)
            PH_IDLE:   if (start)      phase_d = PH_DRAIN;
            PH_DRAIN:  if (tub_empty)  phase_d = PH_SELECT;
            PH_SELECT:                 phase_d = PH_FILL;
            PH_FILL:   if (!tub_empty) phase_d = PH_WASH;
            PH_WASH:   if (tick_ok)    phase_d = PH_RINSE;
            PH_RINSE:  if (tick_ok)    phase_d = PH_DRY;
            PH_DRY:    if (tick_ok)    phase_d = PH_FINISH;
            PH_FINISH:                 phase_d = PH_IDLE;
            default:                   phase_d = PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/wash_temp_reg.sv
module wash_temp_reg (
   input  logic clk,
   input  logic rst,
   input  logic capture,
   input  logic hot_cold,
   output logic hot_q
);

   always_ff @(posedge clk) begin
      if (rst)          hot_q <= 1'b0;
      else if (capture) hot_q <= hot_cold;
   end

endmodule

// File: rtl/wash_out_decode.sv
module wash_out_decode
   import wash_pkg::*;
#(
   parameter int unsigned ACT_W = ACT_COUNT
) (
   input  phase_t           phase_q,
   input  logic             hot_q,
   input  logic             entry_q,
   output logic [ACT_W-1:0] act_en,
   output logic             timer_start,
   output logic             done
);

   for (genvar i = 0; i < ACT_W; i++) begin : g_act
      if (i == ACT_HOT) begin : g_hot
         assign act_en[i] = (phase_q == PH_FILL) && hot_q;
      end else if (i == ACT_COLD) begin : g_cold
         assign act_en[i] = (phase_q == PH_FILL) && !hot_q;
      end else begin : g_plain
         assign act_en[i] = (phase_q == owner_phase(i));
      end
   end

   assign timer_start = entry_q;
   assign done        = (phase_q == PH_FINISH);

endmodule

// File: rtl/wash_seq_ctrl.sv
module wash_seq_ctrl
   import wash_pkg::*;
#(
   parameter int unsigned ACT_W = ACT_COUNT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             hot_cold,
   input  logic             tub_empty,
   input  logic             time_over,
   output logic [ACT_W-1:0] act_en,
   output logic             timer_start,
   output logic             done
);

   initial begin
      if (ACT_W != ACT_COUNT)
         $fatal(1, "wash_seq_ctrl: ACT_W must equal %0d", ACT_COUNT);
   end

   phase_t phase_q;
   phase_t phase_d;
   logic   entry_q;
   logic   hot_q;

   wash_next_phase u_next (
      .phase_q   (phase_q),
      .start     (start),
      .tub_empty (tub_empty),
      .time_over (time_over),
      .entry_q   (entry_q),
      .phase_d   (phase_d)
   );

   wash_temp_reg u_temp (
      .clk      (clk),
      .rst      (rst),
      .capture  (phase_q == PH_SELECT),
      .hot_cold (hot_cold),
      .hot_q    (hot_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         entry_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         entry_q <= (phase_d != phase_q) && is_timed(phase_d);
      end
   end

   wash_out_decode #(.ACT_W(ACT_W)) u_dec (
      .phase_q     (phase_q),
      .hot_q       (hot_q),
      .entry_q     (entry_q),
      .act_en      (act_en),
      .timer_start (timer_start),
      .done        (done)
   );

endmodule

// File: rtl/wash_seq_chk.sv
module wash_seq_chk (
   input logic       clk,
   input logic       rst,
   input logic       start,
   input logic       tub_empty,
   input logic       time_over,
   input logic [5:0] act_en,
   input logic       timer_start,
   input logic       done
);

   a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(act_en));

   a_r9_stop_clears: assert property (@(posedge clk) disable iff (rst)
      !start |=> (act_en == 6'd0) && !timer_start && !done);

   a_r3_drain_holds: assert property (@(posedge clk) disable iff (rst)
      act_en[0] && !tub_empty && start |=> act_en[0]);

   a_r3_select_gap: assert property (@(posedge clk) disable iff (rst)
      act_en[0] && tub_empty && start |=> act_en == 6'd0);

   a_r4_hot_valve_holds: assert property (@(posedge clk) disable iff (rst)
      act_en[1] && tub_empty && start |=> act_en[1]);

   a_r5_fill_exit: assert property (@(posedge clk) disable iff (rst)
      (act_en[1] || act_en[2]) && !tub_empty && start |=> act_en[3]);

   a_r6_timer_pulse: assert property (@(posedge clk) disable iff (rst)
      timer_start |=> !timer_start);

   a_r6_wash_entry: assert property (@(posedge clk) disable iff (rst)
      $rose(act_en[3]) |-> timer_start);

   a_r7_wash_holds: assert property (@(posedge clk) disable iff (rst)
      act_en[3] && start && !time_over |=> act_en[3]);

   a_r7_entry_ignores_time: assert property (@(posedge clk) disable iff (rst)
      act_en[4] && timer_start && start |=> act_en[4]);

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |-> (act_en == 6'd0) ##1 !done);

endmodule

bind wash_seq_ctrl wash_seq_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .start       (start),
   .tub_empty   (tub_empty),
   .time_over   (time_over),
   .act_en      (act_en),
   .timer_start (timer_start),
   .done        (done)
);

// File: tb/tb_wash_seq_ctrl.sv
module tb_wash_seq_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       hot_cold = 1'b0;
   logic       tub_empty = 1'b0;
   logic       time_over = 1'b0;
   logic [5:0] act_en;
   logic       timer_start;
   logic       done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   wash_seq_ctrl dut (
      .clk(clk), .rst(rst), .start(start), .hot_cold(hot_cold),
      .tub_empty(tub_empty), .time_over(time_over),
      .act_en(act_en), .timer_start(timer_start), .done(done)
   );

   // Behavioural reference: 0 idle,1 drain,2 select,3 fill,4 wash,5 rinse,6 dry,7 finish
   int ph = 0;
   bit m_hot = 0;
   bit m_first = 0;
   bit m_stopped = 0;

   always @(posedge clk) begin
      int nx;
      if (rst) begin
         ph = 0; m_hot = 0; m_first = 0; m_stopped = 0;
      end else begin
         m_stopped = (ph != 0) && !start;
         if (m_stopped) nx = 0;
         else case (ph)
            0: nx = start ? 1 : 0;
            1: nx = tub_empty ? 2 : 1;
            2: nx = 3;
            3: nx = tub_empty ? 3 : 4;
            4, 5, 6: nx = (time_over && !m_first) ? ph + 1 : ph;
            default: nx = 0;
         endcase
         if (ph == 2) m_hot = hot_cold;
         m_first = (nx != ph) && (nx >= 4) && (nx <= 6);
         ph = nx;
      end
   end

   function automatic logic [5:0] exp_act();
      case (ph)
         1: return 6'b000001;
         3: return m_hot ? 6'b000010 : 6'b000100;
         4: return 6'b001000;
         5: return 6'b010000;
         6: return 6'b100000;
         default: return 6'b000000;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string phase_tag();
      if (m_stopped) return "R9";
      case (ph)
         0: return "R2";
         1, 2: return "R3";
         3: return "R4";
         7: return "R8";
         default: return "R6";
      endcase
   endfunction

   // One cycle: wait for the falling edge, then compare against the model.
   task automatic step();
      @(negedge clk);
      if (!rst) begin
         check(act_en == exp_act(), phase_tag(), "act_en", act_en, exp_act());
         check(timer_start == m_first, "R6", "timer_start", timer_start, m_first);
         check(done == (ph == 7), "R8", "done", done, ph == 7);
         check($countones(act_en) <= 1, "R10", "onehot", act_en, 0);
      end
   endtask

   task automatic run_program(input bit hot);
      start = 1; hot_cold = hot; tub_empty = 0; time_over = 0;
      step();
      check(act_en == 6'b000001, "R2", "enter drain", act_en, 1);
      repeat (2) step();
      check(act_en == 6'b000001, "R3", "drain hold", act_en, 1);
      tub_empty = 1; step();
      check(act_en == 6'b000000, "R3", "select gap", act_en, 0);
      step();
      hot_cold = !hot;
      repeat (2) step();
      check(act_en == (hot ? 6'b000010 : 6'b000100), "R4", "latched valve",
            act_en, hot ? 2 : 4);
      time_over = 1; tub_empty = 0; step();
      check(act_en == 6'b001000, "R5", "enter wash", act_en, 8);
      check(timer_start == 1, "R6", "wash timer", timer_start, 1);
      step();
      check(act_en == 6'b001000, "R7", "stale time ignored", act_en, 8);
      check(timer_start == 0, "R6", "pulse width", timer_start, 0);
      step();
      check(act_en == 6'b010000 && timer_start, "R6", "enter rinse", act_en, 16);
      time_over = 0; repeat (3) step();
      check(act_en == 6'b010000, "R7", "rinse waits", act_en, 16);
      time_over = 1; step();
      check(act_en == 6'b100000 && timer_start, "R6", "enter dry", act_en, 32);
      step();
      check(act_en == 6'b100000, "R7", "dry entry ignores time", act_en, 32);
      step();
      check(done == 1 && act_en == 0, "R8", "done cycle", done, 1);
      start = 0; step();
      check(done == 0 && act_en == 0, "R8", "back to idle", done, 0);
      time_over = 0;
   endtask

   initial begin
      repeat (3) step();
      rst = 0;
      step();
      check(act_en == 0 && !timer_start && !done, "R1", "reset state", act_en, 0);
      repeat (3) step();
      check(act_en == 0, "R2", "idle without start", act_en, 0);

      run_program(1'b1);
      run_program(1'b0);

      // Abort during wash.
      start = 1; tub_empty = 1; hot_cold = 1;
      for (int i = 0; i < 20 && ph != 4; i++) begin
         if (ph == 3) tub_empty = 0;
         step();
      end
      start = 0; step();
      check(act_en == 0 && !timer_start, "R9", "abort in wash", act_en, 0);

      // Abort during drain.
      start = 1; tub_empty = 0; step(); step();
      start = 0; step();
      check(act_en == 0, "R9", "abort in drain", act_en, 0);

      // Reset in the middle of a run.
      start = 1; step(); step();
      rst = 1; step(); rst = 0; start = 0; step();
      check(act_en == 0 && !done, "R1", "mid-run reset", act_en, 0);

      // Random stimulus, compared every cycle by step().
      for (int i = 0; i < 4000; i++) begin
         start     = ($urandom % 60) != 0;
         tub_empty = ($urandom % 3) != 0;
         time_over = ($urandom % 4) == 0;
         hot_cold  = $urandom % 2;
         step();
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule